// File: doc/BRIEF.md
# Register-Mapped General-Purpose I/O with Pin Interrupts

This block is a general-purpose I/O peripheral that sits on a 32-bit APB-style register bus with zero-wait transfers. It serves up to four ports. Each port has a data register that feeds its pin outputs and a direction register that drives the per-pin output enables. All external pin values pass through a two-flop synchroniser and can be read back through the bus.

The first port (port A) also carries a per-pin interrupt unit. For each pin, software chooses whether the source is switched on, whether it is masked, whether it senses a level or an edge, and which polarity counts as active. Edge events are held until software acknowledges them with a write-one-to-clear end-of-interrupt register. Level sources are not held: they follow the pin. A single active-high interrupt output is high whenever any enabled, unmasked source is pending. Pins of the other ports never raise an interrupt.

Top module: `apb_pio_irq`

## Requirements
- R1: After reset every register reads zero, `pin_out`, `pin_oe` and `irq` are zero, and any address that has no register (including the end-of-interrupt address, 0x4C) always reads zero.
- R2: Port p (0 to 3) has a data register at byte offset 0x0C·p and a direction register at 0x0C·p+4. Both read back what was written, limited to the low PORT_W bits. The data register drives `pin_out` slice p, and the direction register drives `pin_oe` slice p, where 1 makes the pin an output.
- R3: The synchronised value of port p's pins reads at 0x50+4·p. A pin change is visible after the second rising clock edge and not after the first.
- R4: The port A interrupt controls read back at these offsets: enable 0x30 (1 = source on), mask 0x34 (1 = suppressed), type 0x38 (1 = edge, 0 = level), polarity 0x3C (1 = rising/high, 0 = falling/low).
- R5: For a level-type pin, status bit i at 0x40 is enable·¬mask·(pin == polarity), taken from the synchronised pin two edges after the change. It is not latched and drops when the pin leaves the active level.
- R6: For an edge-type enabled pin, an edge in the polarity's direction sets a pending bit after the third rising edge. The bit stays set after the pin returns, and an edge in the other direction sets nothing.
- R7: Writing 1 to bit i of 0x4C clears the held edge event of pin i. Zero bits of the write leave events alone, and level-type status is unaffected by such writes.
- R8: A masked pin keeps its held edge event but shows no status and raises no `irq`; unmasking shows it. A pin whose enable is 0 neither shows status nor stores edges.
- R9: `irq` is high exactly when the status register at 0x40 is nonzero.
- R10: Pins of ports B to D never affect the status register or `irq`, whatever the interrupt settings.
- R11: Reading the status register has no side effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero-extended |
| pin_in | input | NUM_PORTS·PORT_W | External pin values, port A in the low slice |
| pin_out | output | NUM_PORTS·PORT_W | Output data per pin |
| pin_oe | output | NUM_PORTS·PORT_W | Output enable per pin |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The assertions assume the bus follows the two-phase APB order, with a write taking effect only in a cycle where select, enable and write are all high, and they assume `pin_in` is asynchronous and may change at any time. The bench drives every transfer as a setup cycle followed by one access cycle. It changes pins only at falling edges and holds them for at least three cycles before it judges the interrupt state. Interrupt settings are written only after the pins have settled, so no leftover transition sets an event the expected values do not predict.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned BUS_W        = 32;
  localparam int unsigned BANK_STRIDE  = 12;
  localparam int unsigned DIR_OFS      = 4;
  localparam int unsigned PIN_BASE     = 'h50;
  localparam int unsigned PIN_STRIDE   = 4;
  localparam int unsigned IEN_OFS      = 'h30;
  localparam int unsigned IMSK_OFS     = 'h34;
  localparam int unsigned ITYP_OFS     = 'h38;
  localparam int unsigned IPOL_OFS     = 'h3C;
  localparam int unsigned ISTAT_OFS    = 'h40;
  localparam int unsigned IACK_OFS     = 'h4C;

  function automatic int unsigned data_ofs(input int unsigned p);
    return BANK_STRIDE * p;
  endfunction

  function automatic int unsigned dir_ofs(input int unsigned p);
    return BANK_STRIDE * p + DIR_OFS;
  endfunction

  function automatic int unsigned pin_ofs(input int unsigned p);
    return PIN_BASE + PIN_STRIDE * p;
  endfunction
endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pio_port_bank.sv
module pio_port_bank #(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned IDX    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q
);
  import pio_pkg::*;

  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(data_ofs(IDX));
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(dir_ofs(IDX));

  logic          data_we;
  logic          dir_we;
  logic [W-1:0]  data_d;
  logic [W-1:0]  dir_d;

  always_comb begin
    data_we = wr_en && (addr == DATA_A);
    dir_we  = wr_en && (addr == DIR_A);
    data_d  = data_we ? wdata : data_q;
    dir_d   = dir_we  ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
    end
  end
endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit #(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      type_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      pend_q,
  output logic [W-1:0]      evt,
  output logic [W-1:0]      status
);
  import pio_pkg::*;

  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(IEN_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(IMSK_OFS);
  localparam logic [ADDR_W-1:0] TYPE_A = ADDR_W'(ITYP_OFS);
  localparam logic [ADDR_W-1:0] POL_A  = ADDR_W'(IPOL_OFS);
  localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(IACK_OFS);

  logic [W-1:0] prev_q;
  logic [W-1:0] en_d, mask_d, type_d, pol_d, pend_d;
  logic [W-1:0] rise, fall, ack, lvl_hit, edge_live;

  always_comb begin
    en_d   = (wr_en && addr == EN_A)   ? wdata : en_q;
    mask_d = (wr_en && addr == MASK_A) ? wdata : mask_q;
    type_d = (wr_en && addr == TYPE_A) ? wdata : type_q;
    pol_d  = (wr_en && addr == POL_A)  ? wdata : pol_q;
    ack    = (wr_en && addr == ACK_A)  ? wdata : '0;

    rise      = pin & ~prev_q;
    fall      = ~pin & prev_q;
    evt       = en_q & type_q & ((pol_q & rise) | (~pol_q & fall));
    // a new edge in the same cycle as its acknowledge is kept
    pend_d    = evt | (pend_q & en_q & type_q & ~ack);
    edge_live = pend_q & en_q & type_q;
    lvl_hit   = en_q & ~type_q & ~(pin ^ pol_q);
    status    = (edge_live | lvl_hit) & ~mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= pin;
      en_q   <= en_d;
      mask_q <= mask_d;
      type_q <= type_d;
      pol_q  <= pol_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/apb_pio_irq.sv
module apb_pio_irq #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic                          pclk,
  input  logic                          presetn,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [31:0]                   pwdata,
  output logic [31:0]                   prdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
  output logic                          irq
);
  import pio_pkg::*;

  localparam int unsigned PW = NUM_PORTS * PORT_W;

  logic              wr_en;
  logic              wr_ack;
  logic [PW-1:0]     pin_sync;
  logic [PORT_W-1:0] inten, intmask, itype, ipol, pend, edge_evt, istat;

  assign wr_en  = psel && penable && pwrite;
  assign wr_ack = wr_en && (paddr == ADDR_W'(IACK_OFS));

  pio_sync2 #(.W(PW)) u_sync (
    .clk   (pclk),
    .rst_n (presetn),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
    pio_port_bank #(.W(PORT_W), .ADDR_W(ADDR_W), .IDX(p)) u_bank (
      .clk    (pclk),
      .rst_n  (presetn),
      .wr_en  (wr_en),
      .addr   (paddr),
      .wdata  (pwdata[PORT_W-1:0]),
      .data_q (pin_out[p*PORT_W +: PORT_W]),
      .dir_q  (pin_oe[p*PORT_W +: PORT_W])
    );
  end

  pio_irq_unit #(.W(PORT_W), .ADDR_W(ADDR_W)) u_irq (
    .clk    (pclk),
    .rst_n  (presetn),
    .wr_en  (wr_en),
    .addr   (paddr),
    .wdata  (pwdata[PORT_W-1:0]),
    .pin    (pin_sync[PORT_W-1:0]),
    .en_q   (inten),
    .mask_q (intmask),
    .type_q (itype),
    .pol_q  (ipol),
    .pend_q (pend),
    .evt    (edge_evt),
    .status (istat)
  );

  assign irq = |istat;

  always_comb begin
    prdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (paddr == ADDR_W'(data_ofs(p))) prdata[PORT_W-1:0] = pin_out[p*PORT_W +: PORT_W];
      if (paddr == ADDR_W'(dir_ofs(p)))  prdata[PORT_W-1:0] = pin_oe[p*PORT_W +: PORT_W];
      if (paddr == ADDR_W'(pin_ofs(p)))  prdata[PORT_W-1:0] = pin_sync[p*PORT_W +: PORT_W];
    end
    case (paddr)
      ADDR_W'(IEN_OFS):   prdata[PORT_W-1:0] = inten;
      ADDR_W'(IMSK_OFS):  prdata[PORT_W-1:0] = intmask;
      ADDR_W'(ITYP_OFS):  prdata[PORT_W-1:0] = itype;
      ADDR_W'(IPOL_OFS):  prdata[PORT_W-1:0] = ipol;
      ADDR_W'(ISTAT_OFS): prdata[PORT_W-1:0] = istat;
      default: ;
    endcase
  end
endmodule

// File: rtl/apb_pio_irq_chk.sv
module apb_pio_irq_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 32
) (
  input logic                        pclk,
  input logic                        presetn,
  input logic                        wr_en,
  input logic                        wr_ack,
  input logic [31:0]                 pwdata,
  input logic [NUM_PORTS*PORT_W-1:0] pin_out,
  input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0]           inten,
  input logic [PORT_W-1:0]           intmask,
  input logic [PORT_W-1:0]           itype,
  input logic [PORT_W-1:0]           pend,
  input logic [PORT_W-1:0]           edge_evt,
  input logic                        irq
);
  // outputs and direction only move on a bus write
  assert_pins_hold_R2: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

  // interrupt controls only move on a bus write
  assert_ctrl_hold_R4: assert property (@(posedge pclk) disable iff (!presetn)
    !wr_en |=> ($stable(inten) && $stable(intmask) && $stable(itype)));

  // a newly held event needs a pin that was enabled and edge-typed
  assert_pend_source_R6: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(inten & itype)) == '0));

  // acknowledged bits with no fresh edge are gone next cycle
  assert_ack_clears_R7: assert property (@(posedge pclk) disable iff (!presetn)
    wr_ack |=> ((pend & $past(pwdata[PORT_W-1:0] & ~edge_evt)) == '0));

  // the interrupt needs at least one enabled, unmasked pin
  assert_irq_source_R9: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> ((inten & ~intmask) != '0));
endmodule

bind apb_pio_irq apb_pio_irq_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
  .pclk     (pclk),
  .presetn  (presetn),
  .wr_en    (wr_en),
  .wr_ack   (wr_ack),
  .pwdata   (pwdata),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .inten    (inten),
  .intmask  (intmask),
  .itype    (itype),
  .pend     (pend),
  .edge_evt (edge_evt),
  .irq      (irq)
);

// File: tb/apb_pio_irq_tb_top.sv
module apb_pio_irq_tb_top;
  localparam int NP = 4;
  localparam int W  = 8;
  localparam int AW = 7;

  logic              pclk = 1'b0;
  logic              presetn;
  logic              psel, penable, pwrite;
  logic [AW-1:0]     paddr;
  logic [31:0]       pwdata, prdata;
  logic [NP*W-1:0]   pin_in, pin_out, pin_oe;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 pclk = ~pclk;

  apb_pio_irq #(.NUM_PORTS(NP), .PORT_W(W), .ADDR_W(AW)) dut_i (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    psel = 1; pwrite = 1; paddr = AW'(a); pwdata = d;
    @(negedge pclk) penable = 1;
    @(negedge pclk) begin psel = 0; penable = 0; pwrite = 0; end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = AW'(a);
    @(negedge pclk) penable = 1;
    #0.5 d = prdata;
    @(negedge pclk) begin psel = 0; penable = 0; end
  endtask

  task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge pclk);
  endtask

  task automatic set_a(input logic [W-1:0] v);
    pin_in[W-1:0] = v;
  endtask

  task automatic cfg(input logic [W-1:0] en, input logic [W-1:0] msk,
                     input logic [W-1:0] typ, input logic [W-1:0] pol);
    wr('h34, 32'(msk)); wr('h38, 32'(typ)); wr('h3C, 32'(pol)); wr('h30, 32'(en));
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pin_in = '0;
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk);

    // R1: reset state and every word address reading zero
    check("R1 irq", 32'(irq), 0);
    check("R1 pin_oe", pin_oe, 0);
    check("R1 pin_out", pin_out, 0);
    for (int a = 0; a < 'h64; a += 4) chk_rd("R1 reset read", a, 0);

    // R2: data and direction registers per port
    for (int p = 0; p < NP; p++) begin
      logic [W-1:0] dv, ov;
      dv = W'(8'hA5 ^ (p * 8'h11));
      ov = W'(8'h3C + p);
      wr(12 * p, 32'hFFFF_FF00 | 32'(dv));
      wr(12 * p + 4, 32'h5A5A_5A00 | 32'(ov));
    end
    for (int p = 0; p < NP; p++) begin
      logic [W-1:0] dv, ov;
      dv = W'(8'hA5 ^ (p * 8'h11));
      ov = W'(8'h3C + p);
      chk_rd("R2 data readback", 12 * p, 32'(dv));
      chk_rd("R2 dir readback", 12 * p + 4, 32'(ov));
      check("R2 pin_out", 32'(pin_out[p*W +: W]), 32'(dv));
      check("R2 pin_oe", 32'(pin_oe[p*W +: W]), 32'(ov));
    end
    chk_rd("R1 unmapped 0x08", 'h08, 0);
    chk_rd("R1 ack reads zero", 'h4C, 0);

    // R3: pin readback and its two-edge latency
    pin_in = 32'h1E87_4BD2;
    rd('h50, v1);
    check("R3 one edge old value", v1, 0);
    settle();
    for (int p = 0; p < NP; p++)
      chk_rd("R3 pin readback", 'h50 + 4 * p, 32'(pin_in[p*W +: W]));
    pin_in = '0;
    settle();

    // R4: interrupt control readback
    cfg(8'h81, 8'h42, 8'h24, 8'h18);
    chk_rd("R4 enable", 'h30, 32'h81);
    chk_rd("R4 mask", 'h34, 32'h42);
    chk_rd("R4 type", 'h38, 32'h24);
    chk_rd("R4 polarity", 'h3C, 32'h18);
    cfg(0, 0, 0, 0);

    // R5: exact level latency on bit 0, active high
    cfg(8'h01, 0, 0, 8'h01);
    @(negedge pclk) set_a(8'h01);
    @(negedge pclk) #0.5 check("R5 level after one edge", 32'(irq), 0);
    @(negedge pclk) #0.5 check("R5 level after two edges", 32'(irq), 1);
    set_a(0);
    settle();
    cfg(0, 0, 0, 0);

    // R5/R9: level sweep, every bit both polarities
    for (int i = 0; i < W; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [W-1:0] b;
        b = W'(1) << i;
        set_a(pol ? 8'h00 : 8'hFF);
        settle();
        cfg(b, 0, 0, pol ? b : 8'h00);
        check("R5 idle irq", 32'(irq), 0);
        set_a(pol ? b : ~b);
        settle();
        chk_rd("R5 level status", 'h40, 32'(b));
        check("R9 irq level", 32'(irq), 1);
        set_a(pol ? 8'h00 : 8'hFF);
        settle();
        chk_rd("R5 level not held", 'h40, 0);
        check("R9 irq clear", 32'(irq), 0);
        cfg(0, 0, 0, 0);
      end
    end
    set_a(0);
    settle();

    // R6/R7: edge sweep, every bit both directions
    for (int i = 0; i < W; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [W-1:0] b, idle, act;
        b    = W'(1) << i;
        idle = pol ? 8'h00 : 8'hFF;
        act  = pol ? b : ~b;
        set_a(idle);
        settle();
        cfg(b, 0, b, pol ? b : 8'h00);
        set_a(act);
        @(negedge pclk);
        @(negedge pclk) #0.5 check("R6 edge after two edges", 32'(irq), 0);
        @(negedge pclk) #0.5 check("R6 edge after three edges", 32'(irq), 1);
        set_a(idle);
        settle();
        chk_rd("R6 edge held", 'h40, 32'(b));
        wr('h4C, 32'(~b & 8'hFF));
        chk_rd("R7 zero bits keep event", 'h40, 32'(b));
        wr('h4C, 32'(b));
        chk_rd("R7 ack clears", 'h40, 0);
        check("R9 irq after ack", 32'(irq), 0);
        set_a(act);
        settle();
        wr('h4C, 32'(b));
        set_a(idle);
        settle();
        chk_rd("R6 opposite edge ignored", 'h40, 0);
        cfg(0, 0, 0, 0);
      end
    end
    set_a(0);
    settle();

    // R8: mask holds the event hidden; unmask shows it
    cfg(8'h08, 8'h08, 8'h08, 8'h08);
    set_a(8'h08);
    settle();
    chk_rd("R8 masked status", 'h40, 0);
    check("R8 masked irq", 32'(irq), 0);
    wr('h34, 0);
    chk_rd("R8 unmasked status", 'h40, 32'h08);
    check("R8 unmasked irq", 32'(irq), 1);
    // R11: repeated status reads leave it unchanged
    rd('h40, v1);
    rd('h40, v2);
    check("R11 status read twice", v2, v1);
    check("R11 status value", v2, 32'h08);
    wr('h4C, 32'h08);
    set_a(0);
    settle();

    // R8: disabled pin stores no edge
    cfg(8'h00, 0, 8'h10, 8'h10);
    set_a(8'h10);
    settle();
    chk_rd("R8 disabled no status", 'h40, 0);
    wr('h30, 32'h10);
    chk_rd("R8 enable later no stored edge", 'h40, 0);
    cfg(0, 0, 0, 0);
    set_a(0);
    settle();

    // R7: ack writes do not touch level status
    cfg(8'h20, 0, 0, 8'h20);
    set_a(8'h20);
    settle();
    wr('h4C, 32'hFF);
    chk_rd("R7 level survives ack", 'h40, 32'h20);
    cfg(0, 0, 0, 0);
    set_a(0);
    settle();

    // R10: other ports never interrupt (level and edge)
    cfg(8'hFF, 0, 0, 8'hFF);
    pin_in[NP*W-1:W] = '1;
    settle();
    chk_rd("R10 level other ports", 'h40, 0);
    check("R10 level irq", 32'(irq), 0);
    cfg(8'hFF, 0, 8'hFF, 8'h00);
    pin_in[NP*W-1:W] = '0;
    settle();
    chk_rd("R10 edge other ports", 'h40, 0);
    check("R10 edge irq", 32'(irq), 0);
    chk_rd("R3 other ports low", 'h54, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule